// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block arbitrates eight interrupt lines for a processor core. Each line has a sticky pending flag and a 3-bit priority. A smaller value means a more urgent line. A 2-bit grouping setting, changeable at run time, splits every priority into an upper group part and a lower subgroup part. Every cycle the block picks the most urgent pending line. It compares the full priority value first and breaks ties in favour of the lowest line number. The time at which a line became pending plays no part.

The block also keeps a stack of the handlers now running, up to eight deep. A pending line may start, or nest on top of the running handler, only when its group part is strictly more urgent than the running handler's group part. When the core is idle, any pending line may start. The core accepts the offered line with a one-cycle entry pulse and leaves a handler with a one-cycle exit pulse. On exit the handler that was interrupted becomes the running level again.

Top module: `grp_irq_arbiter`

## Requirements
- R1: After reset no line is pending, no handler is running, nothing is offered, every priority is 0 and the grouping setting is 0.
- R2: The pending pick (`pend_id`) is the pending line with the smallest 3-bit priority value. Among lines with equal values the lowest line number wins. The order in which lines became pending has no effect.
- R3: With grouping setting g (values above 3 act as 3), the group part of a priority is its top g bits. With g = 0 every group part is equal.
- R4: When the core is idle, `take_valid` is high whenever a line is pending. While a handler runs, `take_valid` is high only if the pending pick's group part is strictly smaller than the running handler's group part. It stays low when eight handlers are already nested.
- R5: An accepted entry clears the chosen line's pending flag and pushes that line. From the next cycle `run_id` and `run_prio` show the chosen line and its priority.
- R6: An exit pulse removes the running handler. The handler below it becomes the running level again, or the core becomes idle if none is left. An exit pulse while idle has no effect.
- R7: A rising edge on a request input sets that line's pending flag, visible the next cycle. This includes a line whose handler is already running, and such a line is offered again once the running level allows it.
- R8: A new grouping value is used from the cycle after the write. Handlers already running keep their identity and their priority.
- R9: An entry pulse while `take_valid` is low is ignored. When entry and exit arrive in the same cycle, only the exit takes effect.
- R10: Register writes: addresses 0 to 7 load the priority of that line from `wr_data[2:0]`. Address 8 loads the grouping setting from `wr_data[1:0]`. Higher data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Interrupt requests; a rising edge makes a line pending |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0..7 priority, 8 grouping) |
| wr_data | input | 8 | Register write data |
| entry_ack | input | 1 | Core enters the offered line this cycle |
| exit_req | input | 1 | Core leaves the running handler this cycle |
| take_valid | output | 1 | The pending pick may be entered now |
| take_id | output | 3 | Line offered for entry |
| take_prio | output | 3 | Priority of the offered line |
| pend_valid | output | 1 | At least one line is pending |
| pend_id | output | 3 | Most urgent pending line |
| run_active | output | 1 | A handler is running |
| run_id | output | 3 | Line of the running handler |
| run_prio | output | 3 | Priority of the running handler |

## Verification
A stale pending flag or a wrong comparison shows at `pend_id` or `take_valid` in the cycle after the request edge or the entry. The bench sweeps every pair of running and candidate priorities under every grouping value, so a bad group split shows up as a wrong offer decision within a few cycles. A corrupted stack entry stays hidden until the handlers above it exit. For that reason the bench builds a full eight-deep nest and checks every restored level on the way down. A missed pending clear makes the same line reappear immediately when the queue is drained.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int IRQ_LINES  = 8;
  localparam int PRIO_BITS  = 3;
  localparam int GRP_BITS   = 2;
  localparam int NEST_DEPTH = 8;
  localparam int ID_BITS    = $clog2(IRQ_LINES);
  localparam int ADDR_BITS  = $clog2(IRQ_LINES + 1);

  typedef logic [PRIO_BITS-1:0] prio_t;
  typedef logic [ID_BITS-1:0]   line_id_t;

  // upper g bits of a priority; g above the priority width is clamped
  function automatic prio_t group_of(input prio_t p, input logic [GRP_BITS-1:0] g);
    int keep;
    keep = (int'(g) > PRIO_BITS) ? PRIO_BITS : int'(g);
    return p >> (PRIO_BITS - keep);
  endfunction

  // true when (pa, ia) should be served before (pb, ib)
  function automatic logic outranks(input prio_t pa, input line_id_t ia,
                                    input prio_t pb, input line_id_t ib);
    return (pa < pb) || ((pa == pb) && (ia < ib));
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int N = IRQ_LINES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_BITS-1:0]     wr_addr,
  input  logic [7:0]               wr_data,
  output logic [N-1:0][PRIO_BITS-1:0] prio,
  output logic [GRP_BITS-1:0]      grouping
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio[i] <= '0;
      else if (wr_en && (wr_addr == ADDR_BITS'(i)))
        prio[i] <= wr_data[PRIO_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      grouping <= '0;
    else if (wr_en && (wr_addr == ADDR_BITS'(N)))
      grouping <= wr_data[GRP_BITS-1:0];
  end
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_arb_pkg::*;
#(
  parameter int N = IRQ_LINES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           clr_valid,
  input  line_id_t       clr_id,
  output logic [N-1:0]   pend
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_mask;

  assign rise = req & ~req_q;

  always_comb begin
    clr_mask = '0;
    if (clr_valid) clr_mask[clr_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      pend  <= (pend & ~clr_mask) | rise;
    end
  end
endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
  import irq_arb_pkg::*;
#(
  parameter int N = IRQ_LINES
) (
  input  logic [N-1:0]                pend,
  input  logic [N-1:0][PRIO_BITS-1:0] prio,
  output logic                        best_valid,
  output line_id_t                    best_id,
  output prio_t                       best_prio
);
  always_comb begin
    best_valid = 1'b0;
    best_id    = '0;
    best_prio  = '1;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!best_valid || outranks(prio[i], ID_BITS'(i), best_prio, best_id))) begin
        best_valid = 1'b1;
        best_id    = ID_BITS'(i);
        best_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack
  import irq_arb_pkg::*;
#(
  parameter int D = NEST_DEPTH,
  localparam int SW = $clog2(D),
  localparam int DW = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  prio_t         push_prio,
  input  line_id_t      push_id,
  input  logic          pop,
  output logic          top_valid,
  output prio_t         top_prio,
  output line_id_t      top_id,
  output logic          full,
  output logic [DW-1:0] depth
);
  prio_t    prio_mem [D];
  line_id_t id_mem   [D];
  logic [SW-1:0] top_idx;

  assign top_idx   = SW'(depth - DW'(1));
  assign top_valid = (depth != '0);
  assign full      = (depth == DW'(D));
  assign top_prio  = top_valid ? prio_mem[top_idx] : '0;
  assign top_id    = top_valid ? id_mem[top_idx]   : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (pop && top_valid) begin
      depth <= depth - DW'(1);
    end else if (push && !full) begin
      prio_mem[SW'(depth)] <= push_prio;
      id_mem[SW'(depth)]   <= push_id;
      depth <= depth + DW'(1);
    end
  end
endmodule

// File: rtl/grp_irq_arbiter.sv
module grp_irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IRQ_LINES-1:0]  irq_req,
  input  logic                  wr_en,
  input  logic [ADDR_BITS-1:0]  wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  entry_ack,
  input  logic                  exit_req,
  output logic                  take_valid,
  output logic [ID_BITS-1:0]    take_id,
  output logic [PRIO_BITS-1:0]  take_prio,
  output logic                  pend_valid,
  output logic [ID_BITS-1:0]    pend_id,
  output logic                  run_active,
  output logic [ID_BITS-1:0]    run_id,
  output logic [PRIO_BITS-1:0]  run_prio
);
  localparam int DW = $clog2(NEST_DEPTH + 1);

  logic [IRQ_LINES-1:0][PRIO_BITS-1:0] prio;
  logic [GRP_BITS-1:0] grouping;
  logic [IRQ_LINES-1:0] pend;
  logic     best_valid;
  line_id_t best_id;
  prio_t    best_prio;
  logic     top_valid, stack_full;
  prio_t    top_prio;
  line_id_t top_id;
  logic [DW-1:0] depth;

  // named events for the checker
  logic may_preempt;
  logic enter_fire;
  logic pop_fire;

  irq_prio_regs #(.N(IRQ_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prio(prio), .grouping(grouping)
  );

  irq_pend_tracker #(.N(IRQ_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(irq_req),
    .clr_valid(enter_fire), .clr_id(best_id), .pend(pend)
  );

  irq_arb_select #(.N(IRQ_LINES)) u_sel (
    .pend(pend), .prio(prio),
    .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio)
  );

  irq_active_stack #(.D(NEST_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(enter_fire), .push_prio(best_prio), .push_id(best_id),
    .pop(pop_fire),
    .top_valid(top_valid), .top_prio(top_prio), .top_id(top_id),
    .full(stack_full), .depth(depth)
  );

  assign may_preempt = best_valid && !stack_full &&
                       (!top_valid || (group_of(best_prio, grouping) < group_of(top_prio, grouping)));
  assign enter_fire  = entry_ack && may_preempt && !exit_req;
  assign pop_fire    = exit_req && top_valid;

  assign take_valid = may_preempt;
  assign take_id    = best_id;
  assign take_prio  = best_prio;
  assign pend_valid = best_valid;
  assign pend_id    = best_id;
  assign run_active = top_valid;
  assign run_id     = top_id;
  assign run_prio   = top_prio;
endmodule

// File: rtl/grp_irq_arbiter_chk.sv
module grp_irq_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int DW = $clog2(NEST_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 entry_ack,
  input logic                 exit_req,
  input logic                 take_valid,
  input logic [ID_BITS-1:0]   take_id,
  input logic [PRIO_BITS-1:0] take_prio,
  input logic                 pend_valid,
  input logic [ID_BITS-1:0]   pend_id,
  input logic                 run_active,
  input logic [ID_BITS-1:0]   run_id,
  input logic [PRIO_BITS-1:0] run_prio,
  input logic [IRQ_LINES-1:0] pend,
  input logic                 enter_fire,
  input logic                 pop_fire,
  input logic [DW-1:0]        depth
);
  // R2
  pick_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> pend[pend_id]);

  // R4
  offer_matches_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (pend_valid && take_id == pend_id));

  // R5
  entry_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_fire |=> (run_active && run_id == $past(take_id) && run_prio == $past(take_prio)
                    && depth == $past(depth) + DW'(1)));

  // R6
  exit_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (depth == $past(depth) - DW'(1)));

  // R6
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && !run_active) |=> (depth == '0));

  // R9
  ignored_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_ack && !take_valid && !exit_req) |=> $stable(depth));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(NEST_DEPTH));

  // R6
  run_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_active == (depth != '0));
endmodule

bind grp_irq_arbiter grp_irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .entry_ack(entry_ack), .exit_req(exit_req),
  .take_valid(take_valid), .take_id(take_id), .take_prio(take_prio),
  .pend_valid(pend_valid), .pend_id(pend_id), .run_active(run_active),
  .run_id(run_id), .run_prio(run_prio), .pend(pend),
  .enter_fire(enter_fire), .pop_fire(pop_fire), .depth(depth)
);

// File: tb/grp_irq_arbiter_test.sv
module grp_irq_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_req;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       entry_ack, exit_req;
  logic       take_valid, pend_valid, run_active;
  logic [2:0] take_id, take_prio, pend_id, run_id, run_prio;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grp_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .entry_ack(entry_ack), .exit_req(exit_req),
    .take_valid(take_valid), .take_id(take_id), .take_prio(take_prio),
    .pend_valid(pend_valid), .pend_id(pend_id), .run_active(run_active),
    .run_id(run_id), .run_prio(run_prio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] mask);
    irq_req = mask; step();
    irq_req = '0;   step();
  endtask

  task automatic enter();
    entry_ack = 1'b1; step(); entry_ack = 1'b0;
  endtask

  task automatic leave();
    exit_req = 1'b1; step(); exit_req = 1'b0;
  endtask

  // group part by division, an independent form of the split rule
  function automatic int grp(input int p, input int g);
    int gc;
    gc = (g > 3) ? 3 : g;
    return p / (1 << (3 - gc));
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pv[8];
    bit left[8];
    rst_n = 1'b0; irq_req = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    entry_ack = 1'b0; exit_req = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(!pend_valid && !take_valid && !run_active, "R1 idle after reset", int'({pend_valid, take_valid, run_active}), 0);
    pulse(8'h03);
    // all priorities 0 after reset, so line 0 wins the tie (R1, R2)
    chk(pend_id == 3'd0, "R1 reset priorities equal", pend_id, 0);
    enter(); leave(); enter(); leave();
    chk(!pend_valid && !run_active, "R1 drained", int'(pend_valid), 0);

    // R3/R4/R10 sweep: every grouping, every running/candidate priority pair
    for (int g = 0; g < 4; g++) begin
      wr(8, 8'hA4 | g);               // R10: upper data bits ignored
      for (int r = 0; r < 8; r++) begin
        for (int c = 0; c < 8; c++) begin
          bit exp_take;
          wr(0, 8'hF8 | r);
          wr(5, 8'h50 | c);
          pulse(8'h01);
          chk(take_valid && take_id == 3'd0, "R4 idle offers any", int'(take_valid), 1);
          enter();
          chk(run_active && run_prio == 3'(r) && run_id == 3'd0, "R5 entry shows line", run_prio, r);
          pulse(8'h20);
          exp_take = grp(c, g) < grp(r, g);
          chk(pend_valid && pend_id == 3'd5, "R7 new line pending", pend_id, 5);
          chk(take_valid == exp_take, "R3 R4 group preemption", int'(take_valid), int'(exp_take));
          if (exp_take) begin
            enter();
            chk(run_id == 3'd5 && !pend_valid, "R5 nested entry clears pending", run_id, 5);
            leave();
            chk(run_id == 3'd0 && run_prio == 3'(r), "R6 restore lower level", run_id, 0);
            leave();
          end else begin
            leave();
            chk(take_valid && take_id == 3'd5, "R4 offered after return", take_id, 5);
            enter(); leave();
          end
          chk(!run_active && !pend_valid, "R6 back to idle", int'(run_active), 0);
        end
      end
    end

    // R2 pending order sweep, arrival in reverse line order
    for (int k = 1; k < 8; k += 2) begin
      for (int s = 0; s < 8; s++) begin
        for (int tie = 0; tie < 2; tie++) begin
          wr(8, s % 4);
          for (int i = 0; i < 8; i++) begin
            pv[i] = (k * i + s) % 8;
            if (tie == 1) pv[i] = pv[i] / 2;
            wr(i, pv[i]);
            left[i] = 1'b1;
          end
          for (int i = 7; i >= 0; i--) pulse(8'(1 << i));
          for (int n = 0; n < 8; n++) begin
            int best;
            best = -1;
            for (int i = 0; i < 8; i++)
              if (left[i] && (best < 0 || pv[i] < pv[best])) best = i;
            chk(pend_valid && pend_id == 3'(best), "R2 pending pick order", pend_id, best);
            chk(take_valid, "R4 idle offers pick", int'(take_valid), 1);
            enter();
            chk(run_id == 3'(best), "R5 entered pick", run_id, best);
            left[best] = 1'b0;
            leave();
          end
          chk(!pend_valid, "R5 all pending cleared", int'(pend_valid), 0);
        end
      end
    end

    // R6 full eight-deep nesting and unwinding
    wr(8, 3);
    for (int i = 0; i < 8; i++) wr(i, 7 - i);
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      chk(take_valid, "R4 more urgent nests", int'(take_valid), 1);
      enter();
      chk(run_id == 3'(i) && run_prio == 3'(7 - i), "R5 nested top", run_id, i);
    end
    for (int i = 6; i >= 0; i--) begin
      leave();
      chk(run_active && run_id == 3'(i) && run_prio == 3'(7 - i), "R6 unwind restores", run_id, i);
    end
    leave();
    chk(!run_active, "R6 empty after last exit", int'(run_active), 0);
    leave();
    chk(!run_active && !pend_valid, "R6 exit while idle ignored", int'(run_active), 0);

    // R7 re-request of a running line
    wr(3, 2);
    pulse(8'h08); enter();
    pulse(8'h08);
    chk(pend_valid && pend_id == 3'd3, "R7 active line pends again", pend_id, 3);
    chk(!take_valid, "R7 same group waits", int'(take_valid), 0);
    leave();
    chk(take_valid && take_id == 3'd3, "R7 offered after exit", take_id, 3);
    enter(); leave();

    // R8 grouping change, R9 ignored entries
    wr(1, 2); wr(2, 1);
    pulse(8'h02); enter();
    pulse(8'h04);
    chk(take_valid && take_id == 3'd2, "R8 g3 preempts", int'(take_valid), 1);
    wr(8, 1);
    chk(!take_valid, "R8 g1 blocks next cycle", int'(take_valid), 0);
    chk(run_id == 3'd1 && run_prio == 3'd2, "R8 running level kept", run_id, 1);
    enter();
    chk(run_id == 3'd1 && pend_valid && pend_id == 3'd2, "R9 entry without offer ignored", run_id, 1);
    wr(8, 3);
    chk(take_valid, "R8 g3 restored", int'(take_valid), 1);
    entry_ack = 1'b1; exit_req = 1'b1; step();
    entry_ack = 1'b0; exit_req = 1'b0;
    chk(!run_active && pend_valid && pend_id == 3'd2, "R9 exit wins over entry", int'(run_active), 0);
    enter(); leave();
    chk(!run_active && !pend_valid, "R6 final idle", int'(pend_valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule